// File: doc/BRIEF.md
# Selectable Clock-Enable Divider with Fractional Ratio

This block takes a bundle of clock-enable pulse streams, picks one of them with a select field, and thins it into a slower clock-enable stream for a single peripheral. The thinning ratio is a fixed-point number with an integer part and a fraction part, whose widths are chosen per instance. A phase accumulator decides which source pulses pass, so that over a long run the output rate equals the source rate times 2^FRAC_W divided by the divisor value.

Control arrives as plain levels: an enable, a source index and a 32-bit divisor word. A busy flag reports the enable state. An instance built with no integer bits and no fraction bits has no divider and forwards the selected stream as it is.

Top module: `cksel_frac_div`

## Requirements
- R1: Only the source whose index equals `cfg_sel_i` can cause output pulses. An index of `NUM_SRC` or higher selects nothing, and the output stays silent.
- R2: While `cfg_enable_i` is low, `tick_o` is low in the following cycle, whatever the sources do.
- R3: `busy_o` equals the value `cfg_enable_i` had in the previous cycle.
- R4: The divisor value D is `cfg_div_i[12+INT_W-1 : 12-FRAC_W]`. The integer part starts at bit 12 and the fraction takes the FRAC_W bits just below it. All other bits of the word have no effect.
- R5: With D equal to zero, `tick_o` stays low.
- R6: With D greater than 2^FRAC_W, starting from a cleared accumulator, N selected source pulses yield exactly floor(N·2^FRAC_W / D) output pulses. Each source pulse adds 2^FRAC_W, and a pulse is emitted whenever the sum reaches D, after which D is subtracted.
- R7: With D nonzero and not above 2^FRAC_W, every selected source pulse yields one output pulse. The ratio saturates at one to one.
- R8: With INT_W = FRAC_W = 0, `tick_o` is high in the cycle after a cycle in which the block was enabled and the selected source pulsed, and low otherwise.
- R9: An output pulse appears exactly one cycle after the source pulse that completes it. There is never an output pulse without a selected source pulse in the cycle before.
- R10: A change of `cfg_sel_i` clears the accumulator. The source pulse arriving in the cycle of the change starts from zero.
- R11: A cycle with `cfg_enable_i` low clears the accumulator.
- R12: Synchronous active-low reset drives `tick_o` and `busy_o` low and clears the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_pulse_i | input | NUM_SRC | Source clock-enable streams, one bit each |
| cfg_enable_i | input | 1 | Output enable |
| cfg_sel_i | input | SEL_W | Source index |
| cfg_div_i | input | 32 | Divisor word holding the integer.fraction value |
| busy_o | output | 1 | Enable state of the previous cycle |
| tick_o | output | 1 | Divided clock-enable pulse |

## Verification
The bench builds two instances side by side with three sources and a 2-bit select. This leaves select value 3 unused and so exercises the silent out-of-range index. The divided instance uses three integer bits and two fraction bits, so all 32 divisor values are swept. The sweep covers zero, the saturated range at or below 4, and true fractional ratios. It is run with back-to-back and sparse source pulses, and with every non-field bit of the word set. The second instance has no divider and checks that the pass-through variant forwards a varied pulse pattern on each select value.

// File: rtl/cksel_pkg.sv
package cksel_pkg;
    // Width of the divisor word and the fixed boundary between integer and fraction
    localparam int unsigned DIV_WORD_W = 32;
    localparam int unsigned INT_LSB    = 12;
    localparam int unsigned MAX_PART_W = 12;

    // Select width for a given number of sources (at least one bit)
    function automatic int unsigned sel_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/cksel_source_pick.sv
// Picks one clock-enable stream out of NUM_SRC by index.
// Assumes an index at or above NUM_SRC means "no source": the result is 0.
module cksel_source_pick #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned SEL_W   = 3
) (
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               pulse_o
);
    logic [NUM_SRC-1:0] hit;

    // One match line per source; at most one can be high
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_match
        assign hit[g] = src_i[g] && (sel_i == SEL_W'(g));
    end

    // Combine the match lines
    always_comb begin
        pulse_o = |hit;
    end
endmodule

// File: rtl/cksel_div_field.sv
// Extracts the integer.fraction divisor from a 32-bit word.
// Assumes the integer part starts at bit INT_LSB and the fraction sits directly below.
module cksel_div_field
    import cksel_pkg::*;
#(
    parameter int unsigned INT_W  = 4,
    parameter int unsigned FRAC_W = 4,
    localparam int unsigned DW    = INT_W + FRAC_W
) (
    input  logic [DIV_WORD_W-1:0] word_i,
    output logic [DW-1:0]         div_o,
    output logic                  zero_o
);
    localparam int unsigned LSB = INT_LSB - FRAC_W;

    // Copy the field bit by bit from its fixed position
    always_comb begin
        for (int i = 0; i < DW; i++) begin
            div_o[i] = word_i[LSB + i];
        end
    end

    // Flag an all-zero divisor, which silences the output
    always_comb begin
        zero_o = (div_o == '0);
    end
endmodule

// File: rtl/cksel_phase_acc.sv
// Phase accumulator that drops source pulses so the mean output rate is
// rate_in * 2^FRAC_W / D. Assumes D is nonzero whenever enable_i is high;
// ratios above one saturate at one output pulse per source pulse.
module cksel_phase_acc #(
    parameter int unsigned FRAC_W = 4,
    parameter int unsigned DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          restart_i,
    input  logic          pulse_i,
    input  logic [DW-1:0] div_i,
    output logic          tick_o
);
    localparam int unsigned SW = DW + 1;
    localparam logic [SW-1:0] STEP = SW'(1) << FRAC_W;

    logic [DW-1:0] acc_q;
    logic [DW-1:0] base;
    logic [SW-1:0] sum;
    logic [SW-1:0] rem;
    logic [SW-1:0] div_x;
    logic          reach;
    logic [DW-1:0] acc_d;

    // Starting point for this cycle: zero after a restart
    always_comb begin
        base = restart_i ? '0 : acc_q;
    end

    // Add one step and compare with the divisor
    always_comb begin
        div_x = {1'b0, div_i};
        sum   = {1'b0, base} + STEP;
        reach = (sum >= div_x);
        rem   = sum - div_x;
    end

    // Next accumulator value; a remainder still at or above D is dropped
    always_comb begin
        if (!pulse_i) begin
            acc_d = base;
        end else if (!reach) begin
            acc_d = sum[DW-1:0];
        end else if (rem >= div_x) begin
            acc_d = '0;
        end else begin
            acc_d = rem[DW-1:0];
        end
    end

    // Register the accumulator and the output pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else if (!enable_i) begin
            acc_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            tick_o <= pulse_i && reach;
        end
    end
endmodule

// File: rtl/cksel_frac_div.sv
// Clock-enable selector with a fractional divider.
// Assumes src_pulse_i streams are synchronous to clk; INT_W and FRAC_W are at
// most 12 each. With both zero the divider is left out and the selected stream
// is forwarded through one register.
module cksel_frac_div
    import cksel_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned INT_W   = 8,
    parameter int unsigned FRAC_W  = 4,
    localparam int unsigned SEL_W  = sel_width(NUM_SRC),
    localparam int unsigned DW     = INT_W + FRAC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_pulse_i,
    input  logic                  cfg_enable_i,
    input  logic [SEL_W-1:0]      cfg_sel_i,
    input  logic [DIV_WORD_W-1:0] cfg_div_i,
    output logic                  busy_o,
    output logic                  tick_o
);
    logic             pulse_sel;
    logic [SEL_W-1:0] sel_q;
    logic             sel_moved;

    cksel_source_pick #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_pick (
        .src_i   (src_pulse_i),
        .sel_i   (cfg_sel_i),
        .pulse_o (pulse_sel)
    );

    // Remember the previous select and report the enable state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            busy_o <= 1'b0;
        end else begin
            sel_q  <= cfg_sel_i;
            busy_o <= cfg_enable_i;
        end
    end

    // A new select value restarts the phase count
    always_comb begin
        sel_moved = (cfg_sel_i != sel_q);
    end

    if (DW == 0) begin : g_pass
        // Forward the selected stream while enabled
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tick_o <= 1'b0;
            end else begin
                tick_o <= cfg_enable_i && pulse_sel;
            end
        end
    end else begin : g_div
        logic [DW-1:0] div_val;
        logic          div_zero;

        cksel_div_field #(
            .INT_W  (INT_W),
            .FRAC_W (FRAC_W)
        ) u_field (
            .word_i (cfg_div_i),
            .div_o  (div_val),
            .zero_o (div_zero)
        );

        cksel_phase_acc #(
            .FRAC_W (FRAC_W),
            .DW     (DW)
        ) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable_i  (cfg_enable_i && !div_zero),
            .restart_i (sel_moved),
            .pulse_i   (pulse_sel),
            .div_i     (div_val),
            .tick_o    (tick_o)
        );
    end
endmodule

// File: rtl/cksel_frac_div_chk.sv
// Property checker for cksel_frac_div, attached by bind below.
module cksel_frac_div_chk
    import cksel_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned INT_W   = 8,
    parameter int unsigned FRAC_W  = 4,
    parameter int unsigned SEL_W   = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_SRC-1:0]    src_pulse_i,
    input logic                  cfg_enable_i,
    input logic [SEL_W-1:0]      cfg_sel_i,
    input logic [DIV_WORD_W-1:0] cfg_div_i,
    input logic                  busy_o,
    input logic                  tick_o
);
    localparam int unsigned DW = INT_W + FRAC_W;

    logic quiet;

    // No selected pulse this cycle (also true for an out-of-range index)
    always_comb begin
        quiet = 1'b1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if ((int'(cfg_sel_i) == i) && src_pulse_i[i]) quiet = 1'b0;
        end
    end

    assert_reset_R12: assert property (@(posedge clk)
        !rst_n |=> (!tick_o && !busy_o));

    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable_i |=> !tick_o);

    assert_busy_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable_i |=> busy_o);

    assert_busy_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable_i |=> !busy_o);

    // R1 and R9: no output without a selected source pulse one cycle before
    assert_no_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> !tick_o);

    if (DW == 0) begin : g_pass_chk
        assert_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_enable_i && !quiet) |=> tick_o);
    end else begin : g_div_chk
        logic [DIV_WORD_W-1:0] field;
        always_comb begin
            field = (cfg_div_i >> (INT_LSB - FRAC_W)) & ((DIV_WORD_W'(1) << DW) - 1);
        end

        assert_zero_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (field == '0) |=> !tick_o);
    end
endmodule

bind cksel_frac_div cksel_frac_div_chk #(
    .NUM_SRC (NUM_SRC),
    .INT_W   (INT_W),
    .FRAC_W  (FRAC_W),
    .SEL_W   (SEL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_pulse_i  (src_pulse_i),
    .cfg_enable_i (cfg_enable_i),
    .cfg_sel_i    (cfg_sel_i),
    .cfg_div_i    (cfg_div_i),
    .busy_o       (busy_o),
    .tick_o       (tick_o)
);

// File: tb/cksel_frac_div_test.sv
module cksel_frac_div_test;
    localparam int NSRC = 3;
    localparam int FW   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src = '0;
    logic        en = 1'b0;
    logic [1:0]  sel_a = '0;
    logic [1:0]  sel_b = '0;
    logic [31:0] div_a = '0;
    logic [31:0] div_b = '0;
    logic        busy_a, tick_a, busy_b, tick_b;

    int total = 0;
    int bad = 0;
    int cnt_a = 0;
    int cnt_b = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cksel_frac_div #(.NUM_SRC(NSRC), .INT_W(3), .FRAC_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .src_pulse_i(src), .cfg_enable_i(en),
        .cfg_sel_i(sel_a), .cfg_div_i(div_a), .busy_o(busy_a), .tick_o(tick_a));

    cksel_frac_div #(.NUM_SRC(NSRC), .INT_W(0), .FRAC_W(0)) uut_pass (
        .clk(clk), .rst_n(rst_n), .src_pulse_i(src), .cfg_enable_i(en),
        .cfg_sel_i(sel_b), .cfg_div_i(div_b), .busy_o(busy_b), .tick_o(tick_b));

    // Count output pulses away from the active edge
    always @(negedge clk) begin
        cnt_a += int'(tick_a);
        cnt_b += int'(tick_b);
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_ticks(input int d, input int n);
        if (d == 0) return 0;
        if (d <= (1 << FW)) return n;
        return (n * (1 << FW)) / d;
    endfunction

    // Clear the phase, load the divisor, feed n pulses on the selected source
    task automatic run_a(input int d, input bit dirty, input int n, input int gap, input string req);
        @(negedge clk);
        en = 1'b0; src = '0;
        div_a = (32'(d) << 10) | (dirty ? 32'hFFFF_83FF : 32'h0);
        @(negedge clk);
        en = 1'b1; cnt_a = 0;
        for (int i = 0; i < n; i++) begin
            src = '0; src[sel_a] = 1'b1;
            @(negedge clk);
            src = '0;
            repeat (gap) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(req, cnt_a, expect_ticks(d, n));
    endtask

    task automatic pulse_one(input int s);
        src = '0; src[s] = 1'b1;
        @(negedge clk);
        src = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 tick_a", int'(tick_a), 0);
        chk("R12 busy_a", int'(busy_a), 0);
        chk("R12 tick_b", int'(tick_b), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: busy follows enable by one cycle
        en = 1'b1; @(negedge clk);
        chk("R3 busy high", int'(busy_a), 1);
        en = 1'b0; @(negedge clk);
        chk("R3 busy low", int'(busy_a), 0);

        // R4 R5 R6 R7 R9: exhaustive divisor sweep, dense pulses, clean word
        sel_a = 2'd0;
        for (int d = 0; d < 32; d++) run_a(d, 1'b0, 24, 0, "R6 sweep dense");
        // R4: other word bits set, sparse pulses on another source
        sel_a = 2'd2;
        for (int d = 0; d < 32; d++) run_a(d, 1'b1, 17, 2, "R4 sweep dirty");
        sel_a = 2'd1;
        run_a(0, 1'b1, 10, 1, "R5 zero divisor");
        run_a(3, 1'b0, 12, 0, "R7 saturate");
        run_a(13, 1'b0, 40, 1, "R6 ratio 4/13");

        // R10: select change clears the phase (D=7)
        sel_a = 2'd0;
        @(negedge clk); en = 1'b0; div_a = 32'(7) << 10;
        @(negedge clk); en = 1'b1; cnt_a = 0;
        pulse_one(0);
        sel_a = 2'd1;
        pulse_one(1);
        repeat (2) @(negedge clk);
        chk("R10 after switch", cnt_a, 0);
        pulse_one(1);
        repeat (2) @(negedge clk);
        chk("R10 second pulse", cnt_a, 1);

        // R11: a disabled cycle clears the phase (D=7)
        @(negedge clk); en = 1'b0;
        @(negedge clk); en = 1'b1; cnt_a = 0;
        pulse_one(1);
        en = 1'b0; @(negedge clk);
        en = 1'b1;
        pulse_one(1);
        repeat (2) @(negedge clk);
        chk("R11 after disable", cnt_a, 0);

        // R2: pulses while disabled produce nothing
        div_a = 32'(5) << 10;
        en = 1'b0; cnt_a = 0;
        for (int i = 0; i < 10; i++) begin src = 3'b111; @(negedge clk); end
        src = '0; repeat (2) @(negedge clk);
        chk("R2 disabled", cnt_a, 0);

        // R1: unselected sources and an out-of-range index are ignored
        en = 1'b1; sel_a = 2'd0; div_a = 32'(4) << 10;
        @(negedge clk); cnt_a = 0;
        for (int i = 0; i < 10; i++) begin src = 3'b110; @(negedge clk); end
        src = '0; repeat (2) @(negedge clk);
        chk("R1 other sources", cnt_a, 0);
        sel_a = 2'd3; @(negedge clk); cnt_a = 0;
        for (int i = 0; i < 10; i++) begin src = 3'b111; @(negedge clk); end
        src = '0; repeat (2) @(negedge clk);
        chk("R1 out of range", cnt_a, 0);

        // R8: pass-through instance forwards a varied pattern on each index
        for (int s = 0; s < 4; s++) begin
            int exp_n;
            int pat;
            sel_b = 2'(s); en = 1'b1;
            @(negedge clk); cnt_b = 0; exp_n = 0;
            for (int i = 0; i < 20; i++) begin
                pat = (i * 5 + 1) % 8;
                src = 3'(pat);
                if (s < NSRC && pat[s]) exp_n++;
                @(negedge clk);
            end
            src = '0; repeat (2) @(negedge clk);
            chk("R8 pass-through", cnt_b, exp_n);
        end
        // R8 with R2: disabled pass-through is silent
        en = 1'b0; sel_b = 2'd0; @(negedge clk); cnt_b = 0;
        for (int i = 0; i < 6; i++) begin src = 3'b001; @(negedge clk); end
        src = '0; repeat (2) @(negedge clk);
        chk("R8 disabled pass", cnt_b, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule